// File: doc/BRIEF.md
# Protected Oscillator Enable Controller

This block owns the on/off control of a high-speed clock oscillator. Software reaches it through a small register port with two byte-wide locations. One is a power control register whose bit 1 enables the oscillator. The other is a key register that unlocks writes to that enable bit. The block sees which clock the CPU currently runs from and whether the chip is asleep. From these it drives the oscillator enable and a clock-ready flag.

The ready flag stays low after every turn-on until a programmable number of reference-clock cycles has passed, so downstream logic never uses an unsettled clock. Two board strap pins are decoded into a multiplier mode for the clock multiplier that follows the oscillator.

Top module: `osc_enable_ctrl`

## Requirements
- R1: After reset the enable bit is 1 and `osc_on` is 1. The key register holds 0x00 and `clk_ready` is 0. Reading location 0 returns 0x02 and reading location 1 returns 0x00.
- R2: Location 0 is the power control register, and only bit 1 is the enable; all other bits read as 0. Suppose the key register holds 0x96 during a write to location 0. Then wdata bit 1 = 1 sets the enable, and wdata bit 1 = 0 clears it. The new value shows on `bus_rdata` and `osc_on` after the write's clock edge.
- R3: A write to location 0 while the key register holds any value other than 0x96 leaves the enable unchanged.
- R4: While `cpu_src_hs` is 1, an unlocked write that would clear the enable is dropped. An unlocked write that sets the enable still takes effect.
- R5: Location 1 is the key register. A write stores any byte, and a read returns it. Only the value 0x96 unlocks the enable, so writing any other value locks it again.
- R6: `sleep_req` is sampled on each clock edge. While the sampled value is 1, `osc_on` is 0. After the sampled value returns to 0, `osc_on` equals the enable bit again, and that bit may have been written during sleep.
- R7: `clk_ready` rises after `osc_on` has been 1 across `STAB_CYCLES` consecutive clock edges. The count restarts from zero on every off-to-on transition of `osc_on`.
- R8: `clk_ready` is 0 in every cycle in which `osc_on` is 0.
- R9: `mult_mode` decodes `pll_strap` combinationally as follows:

  | `pll_strap` | `mult_mode` | Meaning |
  |---|---|---|
  | 11 | 01 | x2 |
  | 01 | 10 | x4 |
  | 00 | 00 | bypass |
  | 10 (reserved) | 00 | bypass |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 1 | Register select: 0 = power control, 1 = key |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| cpu_src_hs | input | 1 | The CPU currently runs from this oscillator |
| sleep_req | input | 1 | Sleep request, level sensitive |
| pll_strap | input | 2 | Multiplier strap pins |
| osc_on | output | 1 | Oscillator enable |
| clk_ready | output | 1 | Oscillator output is settled and usable |
| mult_mode | output | 2 | Decoded multiplier mode |

## Verification
The bench builds the block with `STAB_CYCLES` = 5 instead of the default 64. With that value, random sleep pulses and unlocked clear writes interrupt the settling count partway through, and they also let it complete, so both restart and completion are exercised many times in a short run. The key constant stays at 0x96. Random key writes are biased toward 0x96 so that locked and unlocked states alternate often. `cpu_src_hs` toggles randomly so that dropped clear writes occur regularly.

// File: rtl/osc_ctl_pkg.sv
package osc_ctl_pkg;

  parameter int unsigned CTL_EN_BIT = 1;

  typedef enum logic [1:0] {
    MM_BYPASS = 2'b00,
    MM_X2     = 2'b01,
    MM_X4     = 2'b10
  } mult_mode_e;

  // Strap decode; reserved code 10 falls back to bypass.
  function automatic mult_mode_e strap_to_mode(input logic [1:0] strap);
    case (strap)
      2'b11:   return MM_X2;
      2'b01:   return MM_X4;
      default: return MM_BYPASS;
    endcase
  endfunction

  // Unlock test for the protection key.
  function automatic logic key_open(input logic [7:0] key, input logic [7:0] magic);
    return key == magic;
  endfunction

endpackage

// File: rtl/osc_key_guard.sv
module osc_key_guard
  import osc_ctl_pkg::*;
#(
  parameter int unsigned DW  = 8,
  parameter logic [DW-1:0] KEY = 8'h96
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          cpu_src_hs,
  output logic [DW-1:0] key_q,
  output logic          en_q,
  output logic          wr_accept,
  output logic          wr_drop_lock,
  output logic          wr_drop_busy
);

  logic wr_ctl;
  logic unlocked;
  logic want_on;

  assign wr_ctl       = bus_wr && !bus_addr;
  assign unlocked     = key_open(key_q, KEY);
  assign want_on      = bus_wdata[CTL_EN_BIT];
  assign wr_drop_lock = wr_ctl && !unlocked;
  assign wr_drop_busy = wr_ctl && unlocked && !want_on && cpu_src_hs;
  assign wr_accept    = wr_ctl && unlocked && !wr_drop_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= '0;
    end else if (bus_wr && bus_addr) begin
      key_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b1;
    end else if (wr_accept) begin
      en_q <= want_on;
    end
  end

endmodule

// File: rtl/osc_stab_timer.sv
module osc_stab_timer #(
  parameter int unsigned STAB_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic ready
);

  localparam int unsigned CNT_W = (STAB_CYCLES < 1) ? 1 : $clog2(STAB_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(STAB_CYCLES);

  logic [CNT_W-1:0] cnt_q;
  logic             done;

  assign done  = (cnt_q == LIMIT);
  assign ready = run && done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (!done) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/osc_mult_decode.sv
module osc_mult_decode
  import osc_ctl_pkg::*;
(
  input  logic [1:0] strap,
  output logic [1:0] mode
);

  mult_mode_e mode_e;

  always_comb begin
    mode_e = strap_to_mode(strap);
    mode   = mode_e;
  end

endmodule

// File: rtl/osc_enable_ctrl.sv
module osc_enable_ctrl
  import osc_ctl_pkg::*;
#(
  parameter int unsigned   DW          = 8,
  parameter logic [DW-1:0] KEY         = 8'h96,
  parameter int unsigned   STAB_CYCLES = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          cpu_src_hs,
  input  logic          sleep_req,
  input  logic [1:0]    pll_strap,
  output logic          osc_on,
  output logic          clk_ready,
  output logic [1:0]    mult_mode
);

  logic [DW-1:0] key_q;
  logic          en_q;
  logic          sleep_q;
  logic          wr_accept;
  logic          wr_drop_lock;
  logic          wr_drop_busy;
  logic [DW-1:0] ctl_view;

  osc_key_guard #(.DW(DW), .KEY(KEY)) u_guard (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .cpu_src_hs   (cpu_src_hs),
    .key_q        (key_q),
    .en_q         (en_q),
    .wr_accept    (wr_accept),
    .wr_drop_lock (wr_drop_lock),
    .wr_drop_busy (wr_drop_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q <= 1'b0;
    end else begin
      sleep_q <= sleep_req;
    end
  end

  assign osc_on = en_q && !sleep_q;

  osc_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (osc_on),
    .ready (clk_ready)
  );

  osc_mult_decode u_dec (
    .strap (pll_strap),
    .mode  (mult_mode)
  );

  always_comb begin
    ctl_view             = '0;
    ctl_view[CTL_EN_BIT] = en_q;
  end

  assign bus_rdata = bus_addr ? key_q : ctl_view;

endmodule

// File: rtl/osc_enable_ctrl_chk.sv
module osc_enable_ctrl_chk #(
  parameter int unsigned   DW  = 8,
  parameter logic [DW-1:0] KEY = 8'h96
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic          bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          cpu_src_hs,
  input logic          sleep_req,
  input logic [DW-1:0] key_q,
  input logic          en_q,
  input logic          osc_on,
  input logic          clk_ready
);

  // R2
  enable_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr && key_q == KEY && bus_wdata[1]) |=> en_q);

  // R3
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr && key_q != KEY) |=> $stable(en_q));

  // R4
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr && !bus_wdata[1] && cpu_src_hs) |=> $stable(en_q));

  // R5
  key_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr) |=> key_q == $past(bus_wdata));

  // R6
  sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |=> !osc_on);

  // R7
  turn_on_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_on) |-> !clk_ready);

  // R8
  off_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_on |-> !clk_ready);

endmodule

bind osc_enable_ctrl osc_enable_ctrl_chk #(.DW(DW), .KEY(KEY)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .cpu_src_hs (cpu_src_hs),
  .sleep_req  (sleep_req),
  .key_q      (key_q),
  .en_q       (en_q),
  .osc_on     (osc_on),
  .clk_ready  (clk_ready)
);

// File: tb/osc_enable_ctrl_bench.sv
module osc_enable_ctrl_bench;

  localparam int unsigned STAB = 5;
  localparam logic [7:0]  MAGIC = 8'h96;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       cpu_src_hs = 1'b0;
  logic       sleep_req = 1'b0;
  logic [1:0] pll_strap = 2'b00;
  logic       osc_on;
  logic       clk_ready;
  logic [1:0] mult_mode;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;

  // Reference state
  logic       m_en;
  logic       m_sleep;
  logic [7:0] m_key;
  int         m_cnt;

  always #4 clk = ~clk;

  osc_enable_ctrl #(.STAB_CYCLES(STAB)) u_osc_enable_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .cpu_src_hs (cpu_src_hs),
    .sleep_req  (sleep_req),
    .pll_strap  (pll_strap),
    .osc_on     (osc_on),
    .clk_ready  (clk_ready),
    .mult_mode  (mult_mode)
  );

  function automatic logic [1:0] exp_mode(input logic [1:0] s);
    if (s == 2'b11) return 2'b01;
    if (s == 2'b01) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic m_osc();
    return m_en & ~m_sleep;
  endfunction

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  // Advance one clock; update the reference with the inputs seen at that edge.
  task automatic step();
    @(posedge clk);
    if (!m_osc()) m_cnt = 0;
    else if (m_cnt < STAB) m_cnt++;
    if (bus_wr && bus_addr) m_key = bus_wdata;
    if (bus_wr && !bus_addr && m_key == MAGIC) begin
      if (bus_wdata[1]) m_en = 1'b1;
      else if (!cpu_src_hs) m_en = 1'b0;
    end
    m_sleep = sleep_req;
    @(negedge clk);
  endtask

  task automatic check_all(input string req_osc);
    check(req_osc, "osc_on", {7'd0, osc_on}, {7'd0, m_osc()});
    if (m_osc()) check("R7", "clk_ready", {7'd0, clk_ready}, {7'd0, m_cnt >= STAB});
    else check("R8", "clk_ready off", {7'd0, clk_ready}, 8'h00);
    if (bus_addr) check("R5", "key read", bus_rdata, m_key);
    else check("R2", "ctl read", bus_rdata, {6'd0, m_en, 1'b0});
    check("R9", "mult_mode", {6'd0, mult_mode}, {6'd0, exp_mode(pll_strap)});
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0c03));
    m_en = 1'b1; m_sleep = 1'b0; m_key = 8'h00; m_cnt = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "osc_on reset", {7'd0, osc_on}, 8'h01);
    check("R1", "ready reset", {7'd0, clk_ready}, 8'h00);
    check("R1", "ctl reset", bus_rdata, 8'h02);
    bus_addr = 1'b1; #1;
    check("R1", "key reset", bus_rdata, 8'h00);
    bus_addr = 1'b0;
    rst_n = 1'b1;

    // R7 settle after reset: ready exactly after STAB edges
    for (int i = 0; i < STAB + 2; i++) begin
      step();
      check("R7", "settle count", {7'd0, clk_ready}, {7'd0, (i + 1) >= STAB});
    end

    // R3 locked clear dropped
    wr(1'b0, 8'h00);
    check("R3", "locked clear", {7'd0, osc_on}, 8'h01);
    // R5 key storage and relock
    wr(1'b1, MAGIC);
    wr(1'b1, 8'h97);
    bus_addr = 1'b1; #1;
    check("R5", "key readback", bus_rdata, 8'h97);
    bus_addr = 1'b0;
    wr(1'b0, 8'h00);
    check("R5", "relocked", {7'd0, osc_on}, 8'h01);
    // R4 busy clear dropped
    wr(1'b1, MAGIC);
    cpu_src_hs = 1'b1;
    wr(1'b0, 8'hFD);
    check("R4", "busy clear", {7'd0, osc_on}, 8'h01);
    cpu_src_hs = 1'b0;
    // R2 clear, then set restarts settling
    wr(1'b0, 8'hFD);
    check("R2", "clear", {7'd0, osc_on}, 8'h00);
    check("R8", "ready after clear", {7'd0, clk_ready}, 8'h00);
    cpu_src_hs = 1'b1;
    wr(1'b0, 8'h02);
    check("R4", "set while busy", {7'd0, osc_on}, 8'h01);
    check("R7", "restart", {7'd0, clk_ready}, 8'h00);
    cpu_src_hs = 1'b0;
    // R6 sleep and restore
    repeat (STAB + 1) step();
    sleep_req = 1'b1;
    step();
    check("R6", "sleep off", {7'd0, osc_on}, 8'h00);
    check("R8", "sleep ready", {7'd0, clk_ready}, 8'h00);
    sleep_req = 1'b0;
    step();
    check("R6", "wake restore", {7'd0, osc_on}, 8'h01);
    // R9 strap codes
    for (int s = 0; s < 4; s++) begin
      pll_strap = 2'(s); #1;
      check("R9", "strap", {6'd0, mult_mode}, {6'd0, exp_mode(2'(s))});
    end

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      bus_wr     = ($urandom % 3) == 0;
      bus_addr   = $urandom % 2;
      bus_wdata  = (bus_addr && ($urandom % 2)) ? MAGIC : 8'($urandom);
      cpu_src_hs = ($urandom % 4) == 0;
      if (($urandom % 16) == 0) sleep_req = ~sleep_req;
      pll_strap  = 2'($urandom);
      step();
      check_all("R6");
    end
    bus_wr = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule